// File: doc/BRIEF.md
# Debug Mode Entry Controller

This block decides when a processor core stops in a halted debug mode and when it may run again. Three sources can request a halt: a request bit that an external scan debugger writes into a small control register, a breakpoint instruction decoded by the pipeline, and a hardware request pin. The breakpoint counts only when a force-breakpoint control bit and an external debug-mode enable bit are both set. All requests are merged into one pending flag, and the core halts only on an instruction-boundary strobe, never in the middle of an instruction.

While the core is halted, the block grants access to the core status/control scan register. An exit command is accepted only after that register has been updated during the current halt. A wakeup control bit drives a clock-restore request to the clock controller. Register writes other than those to the control register or the enable bit are refused with an error flag while the core clock is stopped and the wakeup bit is clear. The halted state also drives a status bit for the instruction-register scan-out.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: After reset, halt_o, dbg_status_o and wakeup_o are 0, all control bits are clear and no request is pending.
- R2: A control write with bit 0 (debug request) set makes halt_o rise on the first later clock edge at which insn_bnd_i is high. halt_o never rises on an edge where insn_bnd_i is low.
- R3: With control bit 0 clear and no other source active, halt_o stays 0 across instruction boundaries.
- R4: With control bit 1 (force breakpoint) set and edm_en_i high, bkpt_dec_i together with insn_bnd_i makes halt_o rise on that edge.
- R5: bkpt_dec_i has no effect when control bit 1 is clear or edm_en_i is low.
- R6: A pulse on hw_req_i is held as pending until the next instruction boundary, which then halts the core. The pending flag clears once the core is halted, so after an exit the core runs on with no new request.
- R7: wakeup_o equals control bit 2 and follows a control write on the next cycle, whatever the value of clk_stopped_i.
- R8: dbg_status_o equals the halted state at all times.
- R9: scr_grant_o is high exactly when scr_acc_i is high and the core is halted.
- R10: While halted, exit_cmd_i clears halt_o on the next edge only if scr_upd_i was seen in an earlier cycle of the same halt. Otherwise it is ignored. Exiting clears this update flag.
- R11: reg_wr_i gives reg_wr_err_o=1 and reg_wr_ok_o=0 when clk_stopped_i is high and wakeup_o is low. Otherwise it gives reg_wr_ok_o=1 and reg_wr_err_o=0.
- R12: An exit accepted on an edge at which a request and a boundary are also present leaves the core running for at least one cycle. A request that is still active then halts it again at the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 3 | Control write data: bit0 request, bit1 force breakpoint, bit2 wakeup |
| edm_en_i | input | 1 | External debug-mode enable from the debug control register |
| hw_req_i | input | 1 | Hardware debug request pin |
| insn_bnd_i | input | 1 | Instruction boundary strobe |
| bkpt_dec_i | input | 1 | Breakpoint instruction decoded |
| exit_cmd_i | input | 1 | Debug exit command |
| scr_acc_i | input | 1 | Status/control scan register access request |
| scr_upd_i | input | 1 | Status/control scan register update done |
| clk_stopped_i | input | 1 | Core clock is stopped (low-power) |
| reg_wr_i | input | 1 | Write to a register other than control/enable |
| halt_o | output | 1 | Core halt |
| wakeup_o | output | 1 | Clock-restore request |
| dbg_status_o | output | 1 | Debug-mode status for scan-out |
| scr_grant_o | output | 1 | Status/control register access granted |
| reg_wr_ok_o | output | 1 | Register write accepted |
| reg_wr_err_o | output | 1 | Register write refused |

## Verification
The exit command and a fresh halt request can land in the same cycle. So can the status-register update and the exit command. The bench drives an exit together with a boundary while the control request bit is still set. It expects one running cycle and then a re-entry at the next boundary. It also presents the update and the exit in the same cycle and expects the exit to be refused, because the update counts only from the following cycle. Seeded random stimulus collides these inputs many more times, and a bench model built from the requirements judges each collision.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;
  localparam int CTL_W    = 3;
  localparam int BIT_REQ  = 0;
  localparam int BIT_FBK  = 1;
  localparam int BIT_WAKE = 2;

  typedef enum logic {ST_RUN = 1'b0, ST_HALT = 1'b1} dbg_st_e;
endpackage

// File: rtl/dbg_ctl_reg.sv
module dbg_ctl_reg #(
  parameter int W = dbg_entry_pkg::CTL_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] ctl_o
);
  logic [W-1:0] ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctl_q <= '0;
    else if (we_i) ctl_q <= wdata_i;
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/dbg_req_merge.sv
module dbg_req_merge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hw_req_i,
  input  logic req_bit_i,
  input  logic fbk_bit_i,
  input  logic edm_en_i,
  input  logic bkpt_dec_i,
  input  logic halted_i,
  output logic req_any_o
);
  logic req_now;
  logic pend_q;

  // breakpoint needs both force bit and external enable
  assign req_now = hw_req_i | req_bit_i | (fbk_bit_i & edm_en_i & bkpt_dec_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pend_q <= 1'b0;
    else if (halted_i) pend_q <= 1'b0;
    else               pend_q <= pend_q | req_now;
  end

  assign req_any_o = pend_q | req_now;

  p_pend_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |=> !pend_q);
endmodule

// File: rtl/dbg_halt_fsm.sv
module dbg_halt_fsm
  import dbg_entry_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic insn_bnd_i,
  input  logic req_any_i,
  input  logic exit_cmd_i,
  input  logic scr_upd_i,
  output logic halted_o
);
  dbg_st_e st_q, st_d;
  logic    upd_q, upd_d;
  logic    exit_ok;

  assign exit_ok = (st_q == ST_HALT) && exit_cmd_i && upd_q;

  always_comb begin
    st_d  = st_q;
    upd_d = upd_q;
    unique case (st_q)
      ST_RUN:  if (insn_bnd_i && req_any_i) st_d = ST_HALT;
      ST_HALT: begin
        if (exit_ok) begin
          st_d  = ST_RUN;
          upd_d = 1'b0;
        end else if (scr_upd_i) begin
          upd_d = 1'b1;
        end
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_RUN;
      upd_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      upd_q <= upd_d;
    end
  end

  assign halted_o = (st_q == ST_HALT);

  p_entry_at_bnd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halted_o) |-> $past(insn_bnd_i && req_any_i));
  p_exit_after_upd_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(halted_o) |-> $past(upd_q && exit_cmd_i));
  p_upd_in_halt_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q |-> halted_o);
endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
  import dbg_entry_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  input  logic             edm_en_i,
  input  logic             hw_req_i,
  input  logic             insn_bnd_i,
  input  logic             bkpt_dec_i,
  input  logic             exit_cmd_i,
  input  logic             scr_acc_i,
  input  logic             scr_upd_i,
  input  logic             clk_stopped_i,
  input  logic             reg_wr_i,
  output logic             halt_o,
  output logic             wakeup_o,
  output logic             dbg_status_o,
  output logic             scr_grant_o,
  output logic             reg_wr_ok_o,
  output logic             reg_wr_err_o
);
  logic [CTL_W-1:0] ctl;
  logic             req_any;
  logic             halted;
  logic             wr_block;

  dbg_ctl_reg #(.W(CTL_W)) u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctl_we_i),
    .wdata_i (ctl_wdata_i),
    .ctl_o   (ctl)
  );

  dbg_req_merge u_merge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hw_req_i   (hw_req_i),
    .req_bit_i  (ctl[BIT_REQ]),
    .fbk_bit_i  (ctl[BIT_FBK]),
    .edm_en_i   (edm_en_i),
    .bkpt_dec_i (bkpt_dec_i),
    .halted_i   (halted),
    .req_any_o  (req_any)
  );

  dbg_halt_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .insn_bnd_i (insn_bnd_i),
    .req_any_i  (req_any),
    .exit_cmd_i (exit_cmd_i),
    .scr_upd_i  (scr_upd_i),
    .halted_o   (halted)
  );

  assign halt_o       = halted;
  assign dbg_status_o = halted;
  assign wakeup_o     = ctl[BIT_WAKE];
  assign scr_grant_o  = scr_acc_i & halted;

  // stopped clock with no wakeup: non-control writes refused
  assign wr_block     = clk_stopped_i & ~ctl[BIT_WAKE];
  assign reg_wr_ok_o  = reg_wr_i & ~wr_block;
  assign reg_wr_err_o = reg_wr_i & wr_block;

  p_wake_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i |=> (wakeup_o == $past(ctl_wdata_i[BIT_WAKE])));
  p_err_gate_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_err_o |-> (clk_stopped_i && !wakeup_o && !reg_wr_ok_o));
  p_grant_halted_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scr_grant_o |-> dbg_status_o);
endmodule

// File: tb/dbg_entry_ctrl_test.sv
`timescale 1ns/1ps
module dbg_entry_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       ctl_we = 0, edm = 0, hw = 0, bnd = 0, bkpt = 0, ex = 0;
  logic       acc = 0, upd = 0, stopped = 0, wr = 0;
  logic [2:0] wd = '0;
  logic halt, wake, stat, grant, ok, err;

  dbg_entry_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .ctl_we_i(ctl_we), .ctl_wdata_i(wd),
    .edm_en_i(edm), .hw_req_i(hw), .insn_bnd_i(bnd), .bkpt_dec_i(bkpt),
    .exit_cmd_i(ex), .scr_acc_i(acc), .scr_upd_i(upd),
    .clk_stopped_i(stopped), .reg_wr_i(wr), .halt_o(halt),
    .wakeup_o(wake), .dbg_status_o(stat), .scr_grant_o(grant),
    .reg_wr_ok_o(ok), .reg_wr_err_o(err)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [2:0] m_ctl = '0;
  logic m_pend = 0, m_halt = 0, m_upd = 0;

  task automatic expect1(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic exp_err(input logic w, input logic s, input logic wk);
    return w & s & ~wk;
  endfunction

  task automatic idle();
    ctl_we = 0; hw = 0; bnd = 0; bkpt = 0; ex = 0; acc = 0; upd = 0; wr = 0;
  endtask

  // check outputs against model, advance one clock, update model
  task automatic tick();
    logic req, any, n_halt, n_upd;
    #1;
    expect1(halt, m_halt, "R2 halt");
    expect1(stat, m_halt, "R8 status");
    expect1(wake, m_ctl[2], "R7 wakeup");
    expect1(grant, acc & m_halt, "R9 grant");
    expect1(err, exp_err(wr, stopped, m_ctl[2]), "R11 err");
    expect1(ok, wr & ~exp_err(1'b1, stopped, m_ctl[2]), "R11 ok");
    @(posedge clk);
    req = hw | m_ctl[0] | (m_ctl[1] & edm & bkpt);
    any = m_pend | req;
    n_halt = m_halt; n_upd = m_upd;
    if (!m_halt && bnd && any) n_halt = 1;
    if (m_halt && ex && m_upd) begin n_halt = 0; n_upd = 0; end
    else if (m_halt && upd) n_upd = 1;
    m_pend = m_halt ? 1'b0 : any;
    m_halt = n_halt; m_upd = n_upd;
    if (ctl_we) m_ctl = wd;
    @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [2:0] v);
    idle(); ctl_we = 1; wd = v; tick(); idle();
  endtask

  task automatic leave();
    idle(); upd = 1; tick(); idle(); ex = 1; tick(); idle();
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    #1;
    expect1(halt, 0, "R1 halt"); expect1(wake, 0, "R1 wakeup");
    expect1(stat, 0, "R1 status");
    rst_n = 1;
    @(negedge clk);
    // R1 + R3: no request, boundaries do nothing
    idle(); bnd = 1; repeat (3) tick();
    expect1(halt, 0, "R3 no request");
    wr_ctl(3'b000); bnd = 1; tick(); idle();
    expect1(halt, 0, "R3 bit0 clear");
    // R2: request bit waits for boundary
    wr_ctl(3'b001); repeat (3) tick();
    expect1(halt, 0, "R2 wait boundary");
    bnd = 1; tick(); idle();
    expect1(halt, 1, "R2 halted at boundary");
    acc = 1; #1; expect1(grant, 1, "R9 grant halted"); idle();
    wr_ctl(3'b000);
    // R10: exit refused without update; update+exit same cycle refused
    ex = 1; tick(); idle();
    expect1(halt, 1, "R10 exit no update");
    upd = 1; ex = 1; tick(); idle();
    expect1(halt, 1, "R10 update same cycle");
    ex = 1; tick(); idle();
    expect1(halt, 0, "R10 exit after update");
    // R6: hw pulse held until boundary
    hw = 1; tick(); idle(); repeat (2) tick();
    expect1(halt, 0, "R6 pending no boundary");
    bnd = 1; tick(); idle();
    expect1(halt, 1, "R6 pending halts");
    ex = 1; tick(); idle();
    expect1(halt, 1, "R10 flag cleared on exit");
    leave();
    expect1(halt, 0, "R10 second exit");
    bnd = 1; repeat (3) tick(); idle();
    expect1(halt, 0, "R6 pending cleared");
    // R5 / R4: breakpoint qualification
    wr_ctl(3'b010); edm = 0; bnd = 1; bkpt = 1; tick(); idle();
    expect1(halt, 0, "R5 edm low");
    wr_ctl(3'b000); edm = 1; bnd = 1; bkpt = 1; tick(); idle();
    expect1(halt, 0, "R5 force bit clear");
    wr_ctl(3'b010); bnd = 1; bkpt = 1; tick(); idle();
    expect1(halt, 1, "R4 breakpoint halts");
    wr_ctl(3'b000); leave(); edm = 0;
    // R12: exit collides with request and boundary
    wr_ctl(3'b001); bnd = 1; tick(); idle();
    upd = 1; tick(); idle();
    ex = 1; bnd = 1; tick(); idle();
    expect1(halt, 0, "R12 exit wins");
    bnd = 1; tick(); idle();
    expect1(halt, 1, "R12 re-entry");
    wr_ctl(3'b000); leave();
    // R11 / R7: write gating by stopped clock and wakeup
    stopped = 1; wr = 1; #1;
    expect1(err, 1, "R11 blocked err"); expect1(ok, 0, "R11 blocked ok");
    wr_ctl(3'b100);
    expect1(wake, 1, "R7 wakeup set while stopped");
    wr = 1; #1;
    expect1(ok, 1, "R11 wakeup ok"); expect1(err, 0, "R11 wakeup err");
    idle(); stopped = 0;
    // random phase
    for (int i = 0; i < 4000; i++) begin
      ctl_we  = ($urandom_range(0, 9) == 0);
      wd      = 3'($urandom_range(0, 7));
      edm     = ($urandom_range(0, 3) != 0);
      hw      = ($urandom_range(0, 19) == 0);
      bnd     = ($urandom_range(0, 1) == 0);
      bkpt    = ($urandom_range(0, 4) == 0);
      ex      = ($urandom_range(0, 3) == 0);
      acc     = ($urandom_range(0, 2) == 0);
      upd     = ($urandom_range(0, 5) == 0);
      stopped = ($urandom_range(0, 2) == 0);
      wr      = ($urandom_range(0, 2) == 0);
      tick();
    end
    idle(); tick();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule